// File: doc/BRIEF.md
# Controller Power-Up Reset Sequencer

This block brings a serial-link controller and its PHY out of reset in a fixed, timed order. A start pulse turns on the supply, then the PHY clock, the bus clock and the core clock. Each of these waits for an acknowledge from the resource it drives. The block then lifts the PHY power-down and waits a short settle interval, so the asynchronous PHY reset has enough reference-clock time to synchronise. Only then does it enable the reference-clock path. After a stabilisation wait it pulses the external device reset pin. It then releases the PHY reset and the core reset and polls a PLL-lock input a bounded number of times. A one-cycle done pulse, or a sticky lock-timeout flag, ends the sequence.

All delays count a single-cycle microsecond strobe, `us_tick`, so one parameter set serves any clock frequency. If any enable step reports failure, the steps already taken are undone one per cycle in reverse order and a failure flag is raised. A stop request returns every output to its reset value from any state. Regulators, clock gates and the PHY itself lie outside the block: they appear only as enable outputs and status inputs.

Top module: `pwrup_seq`

## Requirements
- R1: After `start_i` in idle, the block raises `supply_en_o`, `phy_clk_en_o`, `bus_clk_en_o` and `core_clk_en_o` in that order. It raises each one only after `step_ack_i` has acknowledged the one before. Step index k of `step_ack_i`/`step_fail_i` maps to supply=0, PHY clock=1, bus clock=2, core clock=3, reference clock=4.
- R2: Once the core clock is acknowledged, `phy_pwrdn_o` falls. `ref_clk_en_o` rises exactly SETTLE_US ticks later. The reference clock is never on while the PHY is powered down.
- R3: After the reference clock is acknowledged, at least STABLE_US ticks and at most STABLE_US+1 ticks pass before the device reset becomes active.
- R4: The device reset pin `dev_rst_o` drives its active level equal to `rst_pol_i` (1 = active high) for exactly DEVRST_US ticks. It then returns to the inactive level and stays inactive at every other time.
- R5: When the device reset goes inactive, `phy_rst_o` falls. `core_rst_o` falls on the following cycle, and never before `phy_rst_o`.
- R6: PLL lock is sampled at the end of each LOCK_GAP_US-tick interval after core release. On the first sample that finds `pll_lock_i` high with `extra_wait_i` low, `done_o` pulses for exactly one cycle.
- R7: With `extra_wait_i` high, the block adds EXTRA_US ticks between a successful lock sample and the done pulse.
- R8: If LOCK_TRIES samples all find the lock low, `lock_err_o` rises exactly LOCK_TRIES*LOCK_GAP_US ticks after core release, and no done pulse is produced.
- R9: If `step_fail_i[k]` is seen at step k, the enables k down to 0 are dropped one per cycle in reverse order. A failure at the reference-clock step also reasserts `phy_pwrdn_o`. After that, `fail_o` rises with all enables low.
- R10: `stop_i` in any state yields, on the next cycle, all enables low, `phy_pwrdn_o`, `phy_rst_o` and `core_rst_o` high, the device reset inactive, and `done_o`, `lock_err_o` and `fail_o` low.
- R11: `start_i` has no effect outside the idle state.
- R12: After reset, all enables and flags are low, `phy_pwrdn_o`, `phy_rst_o` and `core_rst_o` are high, and `dev_rst_o` is at the level opposite to `rst_pol_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe per microsecond |
| start_i | input | 1 | Begin power-up sequence (idle only) |
| stop_i | input | 1 | Force everything back into reset |
| rst_pol_i | input | 1 | Active level of the device reset pin |
| extra_wait_i | input | 1 | Add EXTRA_US ticks after lock |
| pll_lock_i | input | 1 | PHY PLL lock status |
| step_ack_i | input | 5 | Per-step enable acknowledge |
| step_fail_i | input | 5 | Per-step enable failure |
| supply_en_o | output | 1 | Supply enable |
| phy_clk_en_o | output | 1 | PHY clock enable |
| bus_clk_en_o | output | 1 | Bus clock enable |
| core_clk_en_o | output | 1 | Core clock enable |
| ref_clk_en_o | output | 1 | Reference clock path enable |
| phy_pwrdn_o | output | 1 | PHY test power-down (high = powered down) |
| phy_rst_o | output | 1 | PHY reset (active high) |
| core_rst_o | output | 1 | Core reset (active high) |
| dev_rst_o | output | 1 | External device reset pin |
| done_o | output | 1 | One-cycle completion pulse |
| lock_err_o | output | 1 | PLL lock timeout flag |
| fail_o | output | 1 | Enable-step failure flag |

## Verification
The sequence is run with an active-high reset and an immediate lock. This confirms the full event order and the exact tick spacing of the settle, stabilise, reset-pulse and lock-gap windows. A second run uses an active-low reset, the extra-wait mode and a lock that appears only at the third sample, which separates the retry path and the extra delay from the immediate case. A lock that never comes checks the timeout count. Failures injected at the bus-clock and reference-clock steps confirm the reverse unwinding, including the power-down reassertion. A stop issued during the reset pulse, and a start issued while running, show that the first forces the reset state and the second is ignored.

// File: rtl/pws_pkg.sv
package pws_pkg;

    localparam int NSTEP    = 5;
    localparam int IDX_W    = 3;
    localparam logic [IDX_W-1:0] IDX_LAST_CLK = 3'd3;
    localparam logic [IDX_W-1:0] IDX_REF      = 3'd4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STEP,
        S_PWRUP,
        S_REF,
        S_STABLE,
        S_DEVRST,
        S_CORE_REL,
        S_LOCK,
        S_EXTRA,
        S_DONE,
        S_RUN,
        S_UNWIND,
        S_FAILED,
        S_LOCKERR
    } seq_state_e;

    typedef struct packed {
        seq_state_e             st;
        logic [IDX_W-1:0]       idx;
        logic [NSTEP-1:0]       en;
        logic                   pwrdn;
        logic                   phy_rst;
        logic                   core_rst;
        logic                   rst_act;
        logic                   done;
        logic                   lock_err;
        logic                   fail;
    } seq_regs_t;

    function automatic seq_regs_t regs_reset();
        seq_regs_t r;
        r.st       = S_IDLE;
        r.idx      = '0;
        r.en       = '0;
        r.pwrdn    = 1'b1;
        r.phy_rst  = 1'b1;
        r.core_rst = 1'b1;
        r.rst_act  = 1'b0;
        r.done     = 1'b0;
        r.lock_err = 1'b0;
        r.fail     = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/pws_us_timer.sv
module pws_us_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pws_try_count.sv
module pws_try_count #(
    parameter int TRIES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = (TRIES < 2) ? 1 : $clog2(TRIES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(TRIES - 1));
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pws_pkg::*;
#(
    parameter int SETTLE_US   = 10,
    parameter int STABLE_US   = 200,
    parameter int DEVRST_US   = 100000,
    parameter int LOCK_GAP_US = 50,
    parameter int LOCK_TRIES  = 2000,
    parameter int EXTRA_US    = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       rst_pol_i,
    input  logic       extra_wait_i,
    input  logic       pll_lock_i,
    input  logic [4:0] step_ack_i,
    input  logic [4:0] step_fail_i,
    output logic       supply_en_o,
    output logic       phy_clk_en_o,
    output logic       bus_clk_en_o,
    output logic       core_clk_en_o,
    output logic       ref_clk_en_o,
    output logic       phy_pwrdn_o,
    output logic       phy_rst_o,
    output logic       core_rst_o,
    output logic       dev_rst_o,
    output logic       done_o,
    output logic       lock_err_o,
    output logic       fail_o
);
    localparam int M1 = (SETTLE_US > STABLE_US) ? SETTLE_US : STABLE_US;
    localparam int M2 = (M1 > DEVRST_US) ? M1 : DEVRST_US;
    localparam int M3 = (M2 > LOCK_GAP_US) ? M2 : LOCK_GAP_US;
    localparam int M4 = (M3 > EXTRA_US) ? M3 : EXTRA_US;
    localparam int TW = $clog2(M4 + 1);

    seq_regs_t      d, q;
    logic           tmr_load, tmr_exp, try_clr, try_inc, try_last;
    logic [TW-1:0]  tmr_val;

    pws_us_timer #(.W(TW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (us_tick),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    pws_try_count #(.TRIES(LOCK_TRIES)) i_tries (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (try_clr),
        .inc   (try_inc),
        .last  (try_last)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        try_clr  = 1'b0;
        try_inc  = 1'b0;
        if (stop_i) begin
            d = regs_reset();
        end else begin
            unique case (q.st)
                S_IDLE: begin
                    if (start_i) begin
                        d.st       = S_STEP;
                        d.idx      = '0;
                        d.en[0]    = 1'b1;
                        d.lock_err = 1'b0;
                        d.fail     = 1'b0;
                    end
                end
                S_STEP: begin
                    if (step_fail_i[q.idx]) begin
                        d.st = S_UNWIND;
                    end else if (step_ack_i[q.idx]) begin
                        if (q.idx == IDX_LAST_CLK) begin
                            d.st     = S_PWRUP;
                            d.pwrdn  = 1'b0;
                            tmr_load = 1'b1;
                            tmr_val  = TW'(SETTLE_US);
                        end else begin
                            d.idx           = q.idx + 3'd1;
                            d.en[q.idx + 3'd1] = 1'b1;
                        end
                    end
                end
                S_PWRUP: begin
                    if (tmr_exp) begin
                        d.st         = S_REF;
                        d.idx        = IDX_REF;
                        d.en[IDX_REF] = 1'b1;
                    end
                end
                S_REF: begin
                    if (step_fail_i[IDX_REF]) begin
                        d.st = S_UNWIND;
                    end else if (step_ack_i[IDX_REF]) begin
                        d.st     = S_STABLE;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(STABLE_US);
                    end
                end
                S_STABLE: begin
                    if (tmr_exp) begin
                        d.st      = S_DEVRST;
                        d.rst_act = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = TW'(DEVRST_US);
                    end
                end
                S_DEVRST: begin
                    if (tmr_exp) begin
                        d.st      = S_CORE_REL;
                        d.rst_act = 1'b0;
                        d.phy_rst = 1'b0;
                    end
                end
                S_CORE_REL: begin
                    d.st       = S_LOCK;
                    d.core_rst = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(LOCK_GAP_US);
                    try_clr    = 1'b1;
                end
                S_LOCK: begin
                    if (tmr_exp) begin
                        if (pll_lock_i) begin
                            if (extra_wait_i) begin
                                d.st     = S_EXTRA;
                                tmr_load = 1'b1;
                                tmr_val  = TW'(EXTRA_US);
                            end else begin
                                d.st   = S_DONE;
                                d.done = 1'b1;
                            end
                        end else if (try_last) begin
                            d.st       = S_LOCKERR;
                            d.lock_err = 1'b1;
                        end else begin
                            try_inc  = 1'b1;
                            tmr_load = 1'b1;
                            tmr_val  = TW'(LOCK_GAP_US);
                        end
                    end
                end
                S_EXTRA: begin
                    if (tmr_exp) begin
                        d.st   = S_DONE;
                        d.done = 1'b1;
                    end
                end
                S_DONE: begin
                    d.st = S_RUN;
                end
                S_UNWIND: begin
                    d.en[q.idx] = 1'b0;
                    if (q.idx == IDX_REF) d.pwrdn = 1'b1;
                    if (q.idx == '0) begin
                        d.st   = S_FAILED;
                        d.fail = 1'b1;
                    end else begin
                        d.idx = q.idx - 3'd1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= regs_reset();
        else        q <= d;
    end

    assign supply_en_o   = q.en[0];
    assign phy_clk_en_o  = q.en[1];
    assign bus_clk_en_o  = q.en[2];
    assign core_clk_en_o = q.en[3];
    assign ref_clk_en_o  = q.en[4];
    assign phy_pwrdn_o   = q.pwrdn;
    assign phy_rst_o     = q.phy_rst;
    assign core_rst_o    = q.core_rst;
    assign dev_rst_o     = q.rst_act ? rst_pol_i : ~rst_pol_i;
    assign done_o        = q.done;
    assign lock_err_o    = q.lock_err;
    assign fail_o        = q.fail;
endmodule

// File: rtl/pws_checker.sv
module pws_checker (
    input logic clk,
    input logic rst_n,
    input logic stop_i,
    input logic rst_pol_i,
    input logic supply_en_o,
    input logic phy_clk_en_o,
    input logic bus_clk_en_o,
    input logic core_clk_en_o,
    input logic ref_clk_en_o,
    input logic phy_pwrdn_o,
    input logic phy_rst_o,
    input logic core_rst_o,
    input logic dev_rst_o,
    input logic done_o,
    input logic lock_err_o,
    input logic fail_o
);
    assert_phy_needs_supply_R1: assert property (@(posedge clk) disable iff (!rst_n)
        phy_clk_en_o |-> supply_en_o);
    assert_bus_needs_phy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clk_en_o |-> phy_clk_en_o);
    assert_core_needs_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en_o |-> bus_clk_en_o);
    assert_ref_needs_core_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ref_clk_en_o |-> core_clk_en_o);
    assert_ref_after_pwrup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_clk_en_o |-> !phy_pwrdn_o);
    assert_devrst_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rst_o == rst_pol_i) |-> (ref_clk_en_o && phy_rst_o && core_rst_o));
    assert_core_after_phy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_o |-> !phy_rst_o);
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_no_done_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err_o |-> !done_o);
    assert_fail_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> !(supply_en_o || phy_clk_en_o || bus_clk_en_o || core_clk_en_o || ref_clk_en_o));
    assert_stop_resets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!supply_en_o && !ref_clk_en_o && phy_pwrdn_o && phy_rst_o && core_rst_o
                    && !done_o && !lock_err_o && !fail_o));
endmodule

bind pwrup_seq pws_checker i_pws_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_i        (stop_i),
    .rst_pol_i     (rst_pol_i),
    .supply_en_o   (supply_en_o),
    .phy_clk_en_o  (phy_clk_en_o),
    .bus_clk_en_o  (bus_clk_en_o),
    .core_clk_en_o (core_clk_en_o),
    .ref_clk_en_o  (ref_clk_en_o),
    .phy_pwrdn_o   (phy_pwrdn_o),
    .phy_rst_o     (phy_rst_o),
    .core_rst_o    (core_rst_o),
    .dev_rst_o     (dev_rst_o),
    .done_o        (done_o),
    .lock_err_o    (lock_err_o),
    .fail_o        (fail_o)
);

// File: tb/test_pwrup_seq.sv
module test_pwrup_seq;
    localparam int SET = 3;
    localparam int STB = 5;
    localparam int DRV = 7;
    localparam int GAP = 2;
    localparam int TRY = 4;
    localparam int EXT = 6;

    localparam int EV_COREREL = 9;
    localparam int EV_RSTACT  = 6;
    localparam int EV_RSTOFF  = 7;
    localparam int EV_PWRUP   = 4;
    localparam int EV_REFON   = 5;
    localparam int EV_DONE    = 10;
    localparam int EV_LOCKERR = 11;
    localparam int NEV        = 19;

    logic clk = 1'b0;
    logic rst_n, us_tick, start, stop, pol, extra, lock;
    logic [4:0] ack, sfail;
    logic sup, phyc, busc, corec, refc, pwrdn, phyr, corer, devr, done, lerr, failo;

    int fail_at = -1;
    int exp_q[$];
    int ev_tick[NEV];
    bit seen[NEV];
    int tick_cnt = 0;
    bit mon_on = 1'b0;
    int done_cnt = 0;
    int unexp = 0;
    int n_chk = 0;
    int n_fail = 0;
    logic [11:0] prev_v = '0;

    always #2 clk = ~clk;

    pwrup_seq #(
        .SETTLE_US(SET), .STABLE_US(STB), .DEVRST_US(DRV),
        .LOCK_GAP_US(GAP), .LOCK_TRIES(TRY), .EXTRA_US(EXT)
    ) i_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start_i(start), .stop_i(stop),
        .rst_pol_i(pol), .extra_wait_i(extra), .pll_lock_i(lock),
        .step_ack_i(ack), .step_fail_i(sfail),
        .supply_en_o(sup), .phy_clk_en_o(phyc), .bus_clk_en_o(busc), .core_clk_en_o(corec),
        .ref_clk_en_o(refc), .phy_pwrdn_o(pwrdn), .phy_rst_o(phyr), .core_rst_o(corer),
        .dev_rst_o(devr), .done_o(done), .lock_err_o(lerr), .fail_o(failo)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit hit(input int e, input logic [11:0] p, input logic [11:0] c);
        case (e)
            0:  return !p[0] && c[0];
            1:  return !p[1] && c[1];
            2:  return !p[2] && c[2];
            3:  return !p[3] && c[3];
            4:  return p[4] && !c[4];
            5:  return !p[5] && c[5];
            6:  return !p[6] && c[6];
            7:  return p[6] && !c[6];
            8:  return p[7] && !c[7];
            9:  return p[8] && !c[8];
            10: return !p[9] && c[9];
            11: return !p[10] && c[10];
            12: return p[5] && !c[5];
            13: return !p[4] && c[4];
            14: return p[3] && !c[3];
            15: return p[2] && !c[2];
            16: return p[1] && !c[1];
            17: return p[0] && !c[0];
            default: return !p[11] && c[11];
        endcase
    endfunction

    // tick strobe: one cycle in four, changed just after the falling edge
    initial begin
        us_tick = 1'b0;
        forever begin
            repeat (3) @(negedge clk);
            #1 us_tick = 1'b1;
            @(negedge clk);
            #1 us_tick = 1'b0;
        end
    end

    // enable acknowledge model with failure injection
    initial begin
        ack = '0;
        sfail = '0;
        forever begin
            @(negedge clk);
            for (int k = 0; k < 5; k++) begin
                logic en_k;
                en_k = (k == 0) ? sup : (k == 1) ? phyc : (k == 2) ? busc : (k == 3) ? corec : refc;
                ack[k]   = en_k && (fail_at != k);
                sfail[k] = en_k && (fail_at == k);
            end
        end
    end

    // monitor: pops expected events and compares them with observed edges
    initial begin
        forever begin
            logic [11:0] cur;
            @(negedge clk);
            if (us_tick) tick_cnt++;
            cur = {failo, lerr, done, corer, phyr, (devr == pol), refc, pwrdn, corec, busc, phyc, sup};
            if (mon_on) begin
                for (int e = 0; e < NEV; e++) begin
                    if (hit(e, prev_v, cur)) begin
                        ev_tick[e] = tick_cnt;
                        seen[e] = 1'b1;
                        n_chk++;
                        if (exp_q.size() == 0) begin
                            n_fail++;
                            unexp++;
                            $display("FAIL R1 unexpected event: actual %0d expected none", e);
                        end else begin
                            int x;
                            x = exp_q.pop_front();
                            if (x != e) begin
                                n_fail++;
                                $display("FAIL R1 event order: actual %0d expected %0d", e, x);
                            end
                        end
                    end
                end
                if (done) done_cnt++;
            end
            prev_v = cur;
        end
    end

    task automatic push_range(input int a, input int b);
        for (int e = a; e <= b; e++) exp_q.push_back(e);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic stop_all();
        mon_on = 1'b0;
        exp_q.delete();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic prep(input logic p, input logic x, input logic l, input int f);
        pol = p; extra = x; lock = l; fail_at = f;
        done_cnt = 0;
        for (int e = 0; e < NEV; e++) seen[e] = 1'b0;
        repeat (2) @(negedge clk);
        mon_on = 1'b1;
    endtask

    task automatic drain(input bit late_lock);
        while (exp_q.size() != 0) begin
            @(negedge clk);
            if (late_lock && seen[EV_COREREL] && (tick_cnt >= ev_tick[EV_COREREL] + 2 * GAP + 1))
                lock = 1'b1;
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; stop = 1'b0; pol = 1'b1; extra = 1'b0; lock = 1'b0;
        repeat (4) @(negedge clk);
        // R12: reset state
        chk(!sup && !phyc && !busc && !corec && !refc, "R12", "enables low", int'({refc, corec, busc, phyc, sup}), 0);
        chk(pwrdn && phyr && corer, "R12", "pwrdn/resets high", int'({pwrdn, phyr, corer}), 7);
        chk(devr == ~pol, "R12", "device reset inactive", int'(devr), int'(~pol));
        chk(!done && !lerr && !failo, "R12", "flags low", int'({done, lerr, failo}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Case A: active-high pin, immediate lock (R1..R6)
        prep(1'b1, 1'b0, 1'b1, -1);
        push_range(0, 9);
        exp_q.push_back(EV_DONE);
        pulse_start();
        drain(1'b0);
        chk(ev_tick[EV_REFON] - ev_tick[EV_PWRUP] == SET, "R2", "settle ticks",
            ev_tick[EV_REFON] - ev_tick[EV_PWRUP], SET);
        chk((ev_tick[EV_RSTACT] - ev_tick[EV_REFON] >= STB) && (ev_tick[EV_RSTACT] - ev_tick[EV_REFON] <= STB + 1),
            "R3", "stabilise ticks", ev_tick[EV_RSTACT] - ev_tick[EV_REFON], STB);
        chk(ev_tick[EV_RSTOFF] - ev_tick[EV_RSTACT] == DRV, "R4", "reset pulse ticks high",
            ev_tick[EV_RSTOFF] - ev_tick[EV_RSTACT], DRV);
        chk(ev_tick[EV_DONE] - ev_tick[EV_COREREL] == GAP, "R6", "first-sample lock ticks",
            ev_tick[EV_DONE] - ev_tick[EV_COREREL], GAP);
        chk(done_cnt == 1, "R6", "done pulse cycles", done_cnt, 1);
        chk(!phyr && !corer, "R5", "resets released", int'({phyr, corer}), 0);
        // R11: start while running is ignored
        begin
            int u0;
            u0 = unexp;
            pulse_start();
            repeat (20) @(negedge clk);
            chk(unexp == u0, "R11", "events after busy start", unexp - u0, 0);
            chk(sup && refc && !done, "R11", "state kept", int'({sup, refc, done}), 6);
        end
        stop_all();

        // Case B: active-low pin, extra wait, lock on third sample (R4, R6, R7)
        prep(1'b0, 1'b1, 1'b0, -1);
        push_range(0, 9);
        exp_q.push_back(EV_DONE);
        pulse_start();
        drain(1'b1);
        chk(ev_tick[EV_RSTOFF] - ev_tick[EV_RSTACT] == DRV, "R4", "reset pulse ticks low",
            ev_tick[EV_RSTOFF] - ev_tick[EV_RSTACT], DRV);
        chk(ev_tick[EV_DONE] - ev_tick[EV_COREREL] == 3 * GAP + EXT, "R7", "late lock plus extra ticks",
            ev_tick[EV_DONE] - ev_tick[EV_COREREL], 3 * GAP + EXT);
        chk(done_cnt == 1, "R7", "done pulse cycles", done_cnt, 1);
        stop_all();

        // Case C: lock never seen (R8)
        prep(1'b1, 1'b0, 1'b0, -1);
        push_range(0, 9);
        exp_q.push_back(EV_LOCKERR);
        pulse_start();
        drain(1'b0);
        chk(ev_tick[EV_LOCKERR] - ev_tick[EV_COREREL] == TRY * GAP, "R8", "timeout ticks",
            ev_tick[EV_LOCKERR] - ev_tick[EV_COREREL], TRY * GAP);
        chk(done_cnt == 0 && lerr, "R8", "no done, error held", done_cnt, 0);
        stop_all();

        // Case D: failure at the bus clock step (R9)
        prep(1'b1, 1'b0, 1'b1, 2);
        push_range(0, 2);
        push_range(15, 18);
        pulse_start();
        drain(1'b0);
        chk(failo && !sup && !phyc && !busc, "R9", "bus failure unwound", int'({failo, busc, phyc, sup}), 8);
        stop_all();

        // Case E: failure at the reference clock step (R9)
        prep(1'b1, 1'b0, 1'b1, 4);
        push_range(0, 5);
        push_range(12, 18);
        pulse_start();
        drain(1'b0);
        chk(failo && pwrdn && !refc && !corec, "R9", "ref failure unwound", int'({failo, pwrdn, refc, corec}), 12);
        stop_all();
        fail_at = -1;

        // Case F: stop during the device reset pulse (R10)
        prep(1'b1, 1'b0, 1'b1, -1);
        mon_on = 1'b0;
        pulse_start();
        while (devr != pol) @(negedge clk);
        @(negedge clk); stop = 1'b1;
        @(negedge clk);
        chk(!sup && !phyc && !busc && !corec && !refc, "R10", "enables dropped", int'({refc, corec, busc, phyc, sup}), 0);
        chk(pwrdn && phyr && corer, "R10", "pwrdn/resets asserted", int'({pwrdn, phyr, corer}), 7);
        chk(devr == ~pol, "R10", "device reset inactive", int'(devr), int'(~pol));
        chk(!done && !lerr && !failo, "R10", "flags cleared", int'({done, lerr, failo}), 0);
        stop = 1'b0;
        repeat (4) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule